// File: doc/BRIEF.md
# Two-Page Transceiver Management Register Space

This block is the byte-addressed register space that sits behind a two-wire serial slave in a pluggable optical module. A separate bus engine decodes start, stop and acknowledge. It hands this block a 7-bit device address, a byte offset, a write strobe with data, and a read strobe. The block answers two device addresses. The identification page holds writable ID bytes and two running checksums. The diagnostics page holds thresholds, a live measurement window, a status/control byte and a 128-byte user area.

The user area is guarded by a two-state lock machine. Its states are `LK_LOCKED` and `LK_OPEN`. The transition `LK_LOCKED -> LK_OPEN` is taken when the four key bytes at diagnostics offsets 123..126 all hold 11h. The transition `LK_OPEN -> LK_LOCKED` is taken as soon as any of those four bytes holds a different value. Both states otherwise hold. Checksums are combinational sums over stored bytes, so every read returns the current value. The status byte mirrors live pin levels.

Top module: `diag_regfile`

## Requirements
- R1: Device address 50h selects the identification page and 51h selects the diagnostics page. Writes to any other device address change nothing, and reads from any other address return FFh.
- R2: `rd_data` takes the addressed byte at the clock edge where `rd_en` is high, and it holds its value in every cycle where `rd_en` is low.
- R3: Identification bytes 0..127 are read/write, except bytes 63 and 95. Identification bytes 128..255 always read 00h, and writes to them are discarded.
- R4: Identification byte 63 reads as the low 8 bits of the sum of bytes 0..62. Identification byte 95 reads as the low 8 bits of the sum of bytes 64..94. Writes to either byte are discarded.
- R5: Diagnostics byte 95 reads as the low 8 bits of the sum of diagnostics bytes 0..94. Diagnostics bytes 0..94 and 106..127 (except 110) are plain read/write storage.
- R6: Diagnostics bytes 96..105 return five 16-bit live words, each with its high byte at the even offset. The words come in this order: temperature, supply, bias, transmit power, receive power. Word k is `meas_words[16k+15:16k]`. Writes to these bytes are discarded.
- R7: Diagnostics byte 110 reads as follows: bit 7 is `pin_txdis`, bit 6 is the soft-disable bit, bit 2 is `pin_fault`, bit 1 is `pin_los`, and all other bits are 0. A write to byte 110 changes only bit 6, and bit 6 drives `soft_tx_off`.
- R8: When diagnostics bytes 123..126 all hold 11h, the lock is open from the second clock edge after the completing write. An access in the cycle straight after that write still sees the lock closed. When any of those bytes departs from 11h, the lock closes again.
- R9: While the lock is closed, reads of diagnostics bytes 128..255 return FFh, and writes to them are discarded without disturbing the stored data.
- R10: While the lock is open, diagnostics bytes 128..255 are read/write storage.
- R11: After reset, all stored bytes are 00h, the soft-disable bit is 0, the lock is closed and `rd_data` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | 7 | Device address of the current access |
| offset | input | 8 | Byte offset within the page |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| meas_words | input | 80 | Five 16-bit live measurement words |
| pin_txdis | input | 1 | Transmitter-disable pin level, synchronous |
| pin_fault | input | 1 | Transmitter-fault pin level, synchronous |
| pin_los | input | 1 | Loss-of-signal pin level, synchronous |
| soft_tx_off | output | 1 | Software transmitter disable |

## Verification
The bench targets the one-cycle latency of the lock. A design that opened the lock combinationally would return user data to a read issued in the cycle right after the fourth key byte is written. The bench also checks that a locked write leaves the stored data intact. A design that dropped the data or let it through would show a wrong value once the lock is opened. Checksums are read back immediately after their covered bytes are written and after a discarded write aimed at the checksum byte itself. A stored, rather than computed, checksum would show either stale values or the written data. Finally, the bench writes all ones to the status byte. Pin-mirror bits that latched the write, or a live-word byte order that was swapped, would show up on the read.

// File: rtl/diag_pkg.sv
package diag_pkg;
    localparam int PAGE_BYTES  = 128;
    localparam int MEAS_CNT    = 5;
    localparam int MEAS_W      = 16;
    localparam int MEAS_BYTES  = MEAS_CNT * MEAS_W / 8;

    localparam logic [6:0] DEV_ID_DEF   = 7'h50;
    localparam logic [6:0] DEV_DIAG_DEF = 7'h51;
    localparam logic [7:0] KEY_BYTE_DEF = 8'h11;

    localparam int OFS_ID_SUM_A = 63;
    localparam int OFS_ID_SUM_B = 95;
    localparam int OFS_DG_SUM   = 95;
    localparam int OFS_MEAS     = 96;
    localparam int OFS_STATUS   = 110;
    localparam int OFS_KEY      = 123;
    localparam int KEY_LEN      = 4;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_st_t;
endpackage

// File: rtl/diag_csum.sv
module diag_csum #(
    parameter int NBYTES = 128,
    parameter int LO     = 0,
    parameter int HI     = 62
) (
    input  logic [8*NBYTES-1:0] page_flat,
    output logic [7:0]          sum
);
    always_comb begin
        sum = 8'h00;
        for (int i = LO; i <= HI; i++) begin
            sum = sum + page_flat[8*i +: 8];
        end
    end
endmodule

// File: rtl/diag_lock_fsm.sv
module diag_lock_fsm
    import diag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_match,
    output logic open_o
);
    lock_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_LOCKED: if (key_match)  st_d = LK_OPEN;
            LK_OPEN:   if (!key_match) st_d = LK_LOCKED;
            default:   st_d = LK_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        open_o = (st_q == LK_OPEN);
    end
endmodule

// File: rtl/diag_regfile.sv
module diag_regfile
    import diag_pkg::*;
#(
    parameter logic [6:0] DEV_ID   = DEV_ID_DEF,
    parameter logic [6:0] DEV_DIAG = DEV_DIAG_DEF,
    parameter logic [7:0] KEY_BYTE = KEY_BYTE_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [6:0]                 dev_addr,
    input  logic [7:0]                 offset,
    input  logic                       wr_en,
    input  logic [7:0]                 wr_data,
    input  logic                       rd_en,
    output logic [7:0]                 rd_data,
    input  logic [MEAS_CNT*MEAS_W-1:0] meas_words,
    input  logic                       pin_txdis,
    input  logic                       pin_fault,
    input  logic                       pin_los,
    output logic                       soft_tx_off
);
    localparam int MEAS_END = OFS_MEAS + MEAS_BYTES - 1;

    logic [7:0] id_mem  [PAGE_BYTES];
    logic [7:0] dg_mem  [PAGE_BYTES];
    logic [7:0] usr_mem [PAGE_BYTES];
    logic [8*PAGE_BYTES-1:0] id_flat, dg_flat;
    logic [7:0] sum_id_a, sum_id_b, sum_dg;
    logic       soft_q, lock_open, key_match;
    logic       sel_id, sel_dg, upper, dg_ro;
    logic [6:0] lo_ofs;
    logic [7:0] rd_next, status_byte, meas_byte, meas_rel;

    assign sel_id = (dev_addr == DEV_ID);
    assign sel_dg = (dev_addr == DEV_DIAG);
    assign upper  = offset[7];
    assign lo_ofs = offset[6:0];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign id_flat[8*g +: 8] = id_mem[g];
        assign dg_flat[8*g +: 8] = dg_mem[g];
    end

    diag_csum #(.NBYTES(PAGE_BYTES), .LO(0), .HI(OFS_ID_SUM_A-1))
        u_sum_id_a (.page_flat(id_flat), .sum(sum_id_a));
    diag_csum #(.NBYTES(PAGE_BYTES), .LO(OFS_ID_SUM_A+1), .HI(OFS_ID_SUM_B-1))
        u_sum_id_b (.page_flat(id_flat), .sum(sum_id_b));
    diag_csum #(.NBYTES(PAGE_BYTES), .LO(0), .HI(OFS_DG_SUM-1))
        u_sum_dg (.page_flat(dg_flat), .sum(sum_dg));

    always_comb begin
        key_match = 1'b1;
        for (int k = 0; k < KEY_LEN; k++) begin
            if (dg_mem[OFS_KEY+k] != KEY_BYTE) key_match = 1'b0;
        end
    end

    diag_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_match(key_match),
        .open_o   (lock_open)
    );

    always_comb begin
        dg_ro = (int'(lo_ofs) == OFS_DG_SUM) || (int'(lo_ofs) == OFS_STATUS) ||
                ((int'(lo_ofs) >= OFS_MEAS) && (int'(lo_ofs) <= MEAS_END));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                id_mem[i]  <= 8'h00;
                dg_mem[i]  <= 8'h00;
                usr_mem[i] <= 8'h00;
            end
            soft_q <= 1'b0;
        end else if (wr_en) begin
            if (sel_id && !upper && int'(lo_ofs) != OFS_ID_SUM_A &&
                int'(lo_ofs) != OFS_ID_SUM_B)
                id_mem[lo_ofs] <= wr_data;
            if (sel_dg && !upper && !dg_ro)
                dg_mem[lo_ofs] <= wr_data;
            if (sel_dg && !upper && int'(lo_ofs) == OFS_STATUS)
                soft_q <= wr_data[6];
            if (sel_dg && upper && lock_open)
                usr_mem[lo_ofs] <= wr_data;
        end
    end

    always_comb begin
        meas_rel    = offset - 8'(OFS_MEAS);
        meas_byte   = meas_words[{meas_rel[3:1], 4'b0000} + (meas_rel[0] ? 7'd0 : 7'd8) +: 8];
        status_byte = {pin_txdis, soft_q, 3'b000, pin_fault, pin_los, 1'b0};
    end

    always_comb begin
        rd_next = 8'hFF;
        if (sel_id) begin
            if (upper)                                rd_next = 8'h00;
            else if (int'(lo_ofs) == OFS_ID_SUM_A)    rd_next = sum_id_a;
            else if (int'(lo_ofs) == OFS_ID_SUM_B)    rd_next = sum_id_b;
            else                                      rd_next = id_mem[lo_ofs];
        end else if (sel_dg) begin
            if (upper)                                rd_next = lock_open ? usr_mem[lo_ofs] : 8'hFF;
            else if (int'(lo_ofs) == OFS_DG_SUM)      rd_next = sum_dg;
            else if (int'(lo_ofs) == OFS_STATUS)      rd_next = status_byte;
            else if (int'(lo_ofs) >= OFS_MEAS && int'(lo_ofs) <= MEAS_END)
                                                      rd_next = meas_byte;
            else                                      rd_next = dg_mem[lo_ofs];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_next;
    end

    assign soft_tx_off = soft_q;
endmodule

// File: rtl/diag_regfile_chk.sv
module diag_regfile_chk
    import diag_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] dev_addr,
    input logic [7:0] offset,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       pin_txdis,
    input logic       pin_fault,
    input logic       pin_los,
    input logic       lock_open
);
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r1_foreign_dev_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dev_addr != DEV_ID_DEF && dev_addr != DEV_DIAG_DEF) |=> rd_data == 8'hFF);

    a_r3_id_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dev_addr == DEV_ID_DEF && offset[7]) |=> rd_data == 8'h00);

    a_r9_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dev_addr == DEV_DIAG_DEF && offset[7] && !lock_open) |=> rd_data == 8'hFF);

    a_r7_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dev_addr == DEV_DIAG_DEF && offset == 8'(OFS_STATUS)) |=>
        (rd_data[7] == $past(pin_txdis) && rd_data[2] == $past(pin_fault) &&
         rd_data[1] == $past(pin_los) && rd_data[5:3] == 3'b000 && rd_data[0] == 1'b0));
endmodule

bind diag_regfile diag_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .offset   (offset),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .pin_txdis(pin_txdis),
    .pin_fault(pin_fault),
    .pin_los  (pin_los),
    .lock_open(lock_open)
);

// File: tb/diag_regfile_bench.sv
module diag_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dev_addr = 7'h00;
    logic [7:0]  offset = 8'h00;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [79:0] meas_words = '0;
    logic        pin_txdis = 1'b0, pin_fault = 1'b0, pin_los = 1'b0;
    logic        soft_tx_off;

    int n_vec = 0;
    int n_bad = 0;
    localparam logic [6:0] ID = 7'h50, DG = 7'h51;

    always #2.5 clk = ~clk;

    diag_regfile u_diag_regfile (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] d, input logic [7:0] o, input logic [7:0] v);
        dev_addr = d; offset = o; wr_data = v; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] d, input logic [7:0] o, output logic [7:0] v);
        dev_addr = d; offset = o; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R11 rd_data after reset", rd_data, 8'h00);
        chk("R11 soft_tx_off after reset", {7'h0, soft_tx_off}, 8'h00);
        rd(ID, 8'd5, v);   chk("R11 id byte cleared", v, 8'h00);
        rd(DG, 8'd200, v); chk("R11 user area locked at reset", v, 8'hFF);
    endtask

    task automatic t_id_page;
        logic [7:0] v, sa, sb;
        sa = 0; sb = 0;
        for (int i = 0; i < 63; i++) begin wr(ID, 8'(i), 8'(i*3+1)); sa += 8'(i*3+1); end
        for (int i = 64; i < 95; i++) begin wr(ID, 8'(i), 8'(i^8'hA5)); sb += 8'(i^8'hA5); end
        rd(ID, 8'd10, v);  chk("R3 id byte readback", v, 8'd31);
        rd(ID, 8'd63, v);  chk("R4 id checksum 0..62", v, sa);
        rd(ID, 8'd95, v);  chk("R4 id checksum 64..94", v, sb);
        wr(ID, 8'd63, 8'h3C);
        rd(ID, 8'd63, v);  chk("R4 write to checksum discarded", v, sa);
        wr(ID, 8'd0, 8'h80); sa = sa - 8'd1 + 8'h80;
        rd(ID, 8'd63, v);  chk("R4 checksum follows change", v, sa);
        wr(ID, 8'd200, 8'hAA);
        rd(ID, 8'd200, v); chk("R3 id upper reads zero", v, 8'h00);
    endtask

    task automatic t_diag_sum;
        logic [7:0] v, s;
        s = 0;
        for (int i = 0; i < 95; i++) begin wr(DG, 8'(i), 8'(i*7+3)); s += 8'(i*7+3); end
        rd(DG, 8'd95, v);  chk("R5 diag checksum 0..94", v, s);
        wr(DG, 8'd120, 8'h5E);
        rd(DG, 8'd120, v); chk("R5 plain diag byte", v, 8'h5E);
    endtask

    task automatic t_live;
        logic [7:0] v;
        meas_words = {16'h9A0B, 16'h7C8D, 16'h5E6F, 16'h3041, 16'h1223};
        rd(DG, 8'd96, v);  chk("R6 temperature high byte", v, 8'h12);
        rd(DG, 8'd97, v);  chk("R6 temperature low byte", v, 8'h23);
        rd(DG, 8'd100, v); chk("R6 bias high byte", v, 8'h5E);
        rd(DG, 8'd105, v); chk("R6 rx power low byte", v, 8'h0B);
        wr(DG, 8'd98, 8'hEE);
        rd(DG, 8'd98, v);  chk("R6 live byte read-only", v, 8'h30);
    endtask

    task automatic t_status;
        logic [7:0] v;
        pin_txdis = 1; pin_fault = 0; pin_los = 1;
        rd(DG, 8'd110, v); chk("R7 pins mirrored", v, 8'h82);
        wr(DG, 8'd110, 8'hFF);
        pin_txdis = 0; pin_fault = 1; pin_los = 0;
        rd(DG, 8'd110, v); chk("R7 only soft bit written", v, 8'h44);
        chk("R7 soft_tx_off driven", {7'h0, soft_tx_off}, 8'h01);
        wr(DG, 8'd110, 8'h00);
        rd(DG, 8'd110, v); chk("R7 soft bit cleared", v, 8'h04);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        wr(DG, 8'd130, 8'h77);
        rd(DG, 8'd130, v); chk("R9 locked read FF", v, 8'hFF);
        wr(DG, 8'd123, 8'h11); wr(DG, 8'd124, 8'h11); wr(DG, 8'd125, 8'h11);
        rd(DG, 8'd130, v); chk("R8 three key bytes not enough", v, 8'hFF);
        wr(DG, 8'd126, 8'h11);
        rd(DG, 8'd130, v); chk("R8 cycle after key still locked", v, 8'hFF);
        rd(DG, 8'd130, v); chk("R9 locked write was discarded", v, 8'h00);
        wr(DG, 8'd130, 8'h77);
        rd(DG, 8'd130, v); chk("R10 unlocked readback", v, 8'h77);
        wr(DG, 8'd255, 8'hC3);
        rd(DG, 8'd255, v); chk("R10 last user byte", v, 8'hC3);
        wr(DG, 8'd124, 8'h12);
        rd(DG, 8'd126, v); // idle-ish access lets the lock state settle
        rd(DG, 8'd130, v); chk("R8 relocked after key change", v, 8'hFF);
        wr(DG, 8'd130, 8'h01);
        wr(DG, 8'd124, 8'h11);
        rd(DG, 8'd126, v);
        rd(DG, 8'd130, v); chk("R9 data kept across relock", v, 8'h77);
    endtask

    task automatic t_foreign_and_hold;
        logic [7:0] v;
        wr(7'h52, 8'd10, 8'h99);
        rd(7'h52, 8'd10, v); chk("R1 foreign device reads FF", v, 8'hFF);
        rd(ID, 8'd10, v);    chk("R1 foreign write ignored", v, 8'd31);
        dev_addr = DG; offset = 8'd20;
        repeat (3) @(negedge clk);
        chk("R2 rd_data held without rd_en", rd_data, 8'd31);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(5 * 100000);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id_page();
        t_diag_sum();
        t_live();
        t_status();
        t_lock();
        t_foreign_and_hold();
        summary();
    end
endmodule